// File: doc/BRIEF.md
# Signal Unit Error Rate Monitor

This block watches the stream of signalling units that a receive link delivers and keeps a running measure of how many of them arrive damaged. Every received unit, good or errored, advances an 8-bit unit counter. Every errored unit adds one to an error counter, and each time the unit counter wraps, one error is forgiven. The result is a leaky bucket: a steady trickle of faults is absorbed, and a burst fills the bucket.

The bucket depth is selected by one input: 64 by default, 32 when the select bit is high. An errored unit that arrives with the bucket already full is an excess event. The error counter then holds at the depth and a one-cycle interrupt pulse is produced unless the mask input is high. When the excess comes from aborted or invalid frames, the pulse is re-issued at a fixed period until a good unit arrives. While the receiver is counting raw octets because it has lost framing, each group of 16 octets counts as one aborted unit. A clear command zeroes both counters and stops the repeat.

Top module: `su_err_monitor`

## Requirements
- R1: After reset (rst_n low) or after a cycle with cnt_clr high, su_count and err_count read 0, irq is low and no repeated interrupt follows until a new excess event occurs.
- R2: Outside octet mode, each cycle with su_done high counts one unit, so su_count advances by one. A counted octet group also advances it by one. su_count wraps from 255 to 0.
- R3: A unit with su_bad or su_abort high is errored. When err_count is below the threshold, an errored unit adds one to err_count.
- R4: When a unit makes su_count wrap from 255 to 0, err_count drops by one in that same update. This happens only if err_count is nonzero and the counter is not saturated.
- R5: The threshold is 64 when thr_sel is 0 and 32 when thr_sel is 1. An errored unit that arrives with err_count at or above the threshold is an excess event. It sets err_count to the threshold and marks the counter saturated. A saturated counter is not decremented by wraps. A valid unit (su_done high, su_bad and su_abort low) or a clear ends saturation.
- R6: Each excess event drives irq high for exactly the one cycle after the clock edge that sampled it. Excess events on back-to-back cycles give back-to-back pulses.
- R7: While irq_mask is 1, excess events and repeats produce no pulse, and nothing is held pending for later.
- R8: An excess event caused by an aborted unit (su_abort high, or an octet group) starts a repeat. irq is re-issued every RPT_PERIOD cycles after the last pulse event until a valid unit or a clear. Excess events from su_bad alone start no repeat.
- R9: With oct_mode high, su_done is ignored. Every 16th oct_tick counts as one aborted errored unit. The octet phase restarts whenever oct_mode is low.
- R10: cnt_clr takes priority over every strobe sampled in the same cycle. None of those strobes is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| su_done | input | 1 | End of one received signalling unit |
| su_bad | input | 1 | The finishing unit failed its checks |
| su_abort | input | 1 | The finishing unit was aborted or invalid |
| oct_mode | input | 1 | Receiver is in octet-counting mode |
| oct_tick | input | 1 | One octet received in octet-counting mode |
| thr_sel | input | 1 | Threshold select: 0 gives 64, 1 gives 32 |
| cnt_clr | input | 1 | Clear command for both counters |
| irq_mask | input | 1 | 1 suppresses the interrupt |
| irq | output | 1 | One-cycle interrupt pulse |
| su_count | output | UNIT_W (8) | Unit counter |
| err_count | output | ERR_W (7) | Error counter |

## Verification
Both counters are visible at the ports, so a wrong increment, a missed leak or a wrong saturation value shows in su_count or err_count one edge after the strobe that caused it. A fault in the saturation flag or the repeat state is hidden at first. It shows only later: as a wrong leak at the next unit-counter wrap, or as a missing or extra irq pulse one repeat period after the excess. For that reason the reference model is compared on every cycle over long mixed runs, and directed runs cross a wrap and several repeat periods.

// File: rtl/su_err_pkg.sv
// su_err_pkg: shared types for the signalling-unit error monitor.
// Assumes: at most one unit event is reported per cycle.
package su_err_pkg;

    // Classified unit event for one cycle
    typedef struct packed {
        logic valid;        // good unit finished
        logic errd;         // errored unit (bad, aborted, or octet group)
        logic abort_cause;  // errored unit came from an abort or an octet group
    } su_evt_t;

endpackage

// File: rtl/su_evt_decode.sv
// su_evt_decode: turns the raw strobes into one classified event per cycle.
// In octet mode su_done is ignored and each OCT_GROUP-th octet tick yields
// one aborted errored unit. A clear command masks every event of its cycle.
// Assumes: OCT_GROUP is a power of two of at least 2.
module su_evt_decode
    import su_err_pkg::*;
#(
    parameter int OCT_GROUP = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cnt_clr,
    input  logic    su_done,
    input  logic    su_bad,
    input  logic    su_abort,
    input  logic    oct_mode,
    input  logic    oct_tick,
    output su_evt_t evt
);
    localparam int PH_W = $clog2(OCT_GROUP);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OCT_GROUP - 1);

    logic [PH_W-1:0] phase;
    logic            direct;
    logic            grp;

    // Octet phase: restarts outside octet mode and on clear
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr || !oct_mode) begin
            phase <= '0;
        end else if (oct_tick) begin
            phase <= (phase == PH_LAST) ? '0 : phase + PH_W'(1);
        end
    end

    // Event classification for the current cycle
    always_comb begin
        direct          = !oct_mode && su_done;
        grp             = oct_mode && oct_tick && (phase == PH_LAST);
        evt.valid       = !cnt_clr && direct && !su_bad && !su_abort;
        evt.errd        = !cnt_clr && ((direct && (su_bad || su_abort)) || grp);
        evt.abort_cause = !cnt_clr && ((direct && su_abort) || grp);
    end

endmodule

// File: rtl/su_unit_ctr.sv
// su_unit_ctr: free-running unit counter that marks its own wrap.
// Assumes: unit_evt is already gated by the clear command.
module su_unit_ctr #(
    parameter int UNIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clr,
    input  logic              unit_evt,
    output logic [UNIT_W-1:0] count,
    output logic              wrap
);
    // Wrap happens when a unit arrives at the top count
    always_comb wrap = unit_evt && (count == '1);

    // Count units, modulo 2**UNIT_W
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) begin
            count <= '0;
        end else if (unit_evt) begin
            count <= count + UNIT_W'(1);
        end
    end

endmodule

// File: rtl/su_err_bucket.sv
// su_err_bucket: leaky-bucket error counter with a selectable depth.
// It fills by one per errored unit and leaks by one per unit-counter wrap.
// An errored unit arriving at or above the depth is an excess event: the
// counter is pinned at the depth and stays there, with no leak, until a
// valid unit or a clear.
// Assumes: evt is gated by the clear command.
module su_err_bucket
    import su_err_pkg::*;
#(
    parameter int THR_HI = 64,
    parameter int THR_LO = 32,
    parameter int ERR_W  = $clog2(THR_HI + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             thr_sel,
    input  su_evt_t          evt,
    input  logic             wrap,
    output logic [ERR_W-1:0] err_count,
    output logic             excess
);
    localparam logic [ERR_W-1:0] THR_HI_V = ERR_W'(THR_HI);
    localparam logic [ERR_W-1:0] THR_LO_V = ERR_W'(THR_LO);

    logic [ERR_W-1:0] thr;
    logic             sat;
    logic             leak;
    logic [ERR_W-1:0] err_nxt;

    // Depth, excess and leak decisions for this cycle
    always_comb begin
        thr    = thr_sel ? THR_LO_V : THR_HI_V;
        excess = evt.errd && (err_count >= thr);
        leak   = wrap && !sat && (err_count != '0);
        if (excess) begin
            err_nxt = thr;
        end else if (evt.errd) begin
            err_nxt = err_count + ERR_W'(1) - ERR_W'(leak);
        end else begin
            err_nxt = err_count - ERR_W'(leak);
        end
    end

    // Error counter and saturation flag registers
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) begin
            err_count <= '0;
            sat       <= 1'b0;
        end else begin
            err_count <= err_nxt;
            if (excess) begin
                sat <= 1'b1;
            end else if (evt.valid) begin
                sat <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/su_irq_gen.sv
// su_irq_gen: turns excess events into one-cycle interrupt pulses and
// re-issues them every RPT_PERIOD cycles while an abort-caused excess stands.
// The mask suppresses pulses outright; nothing is held pending.
// Assumes: RPT_PERIOD is a power of two of at least 2.
module su_irq_gen #(
    parameter int RPT_PERIOD = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_clr,
    input  logic excess,
    input  logic abort_cause,
    input  logic valid,
    input  logic irq_mask,
    output logic irq
);
    localparam int TMR_W = $clog2(RPT_PERIOD);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(RPT_PERIOD - 1);

    logic             rpt;
    logic [TMR_W-1:0] tmr;
    logic             fire;

    // A repeat is due when the period has run out and no valid unit ends it
    always_comb fire = rpt && (tmr == TMR_LAST) && !valid;

    // Repeat state, period timer and pulse register
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) begin
            rpt <= 1'b0;
            tmr <= '0;
            irq <= 1'b0;
        end else begin
            irq <= (excess || fire) && !irq_mask;
            if (excess && abort_cause) begin
                rpt <= 1'b1;
            end else if (valid) begin
                rpt <= 1'b0;
            end
            if (excess || fire || valid || !rpt) begin
                tmr <= '0;
            end else begin
                tmr <= tmr + TMR_W'(1);
            end
        end
    end

endmodule

// File: rtl/su_err_monitor.sv
// su_err_monitor: top of the signalling-unit error rate monitor.
// Wires the event decoder, unit counter, error bucket and interrupt generator.
// Assumes: synchronous active-low reset and at most one unit end per cycle.
module su_err_monitor
    import su_err_pkg::*;
#(
    parameter int UNIT_W     = 8,
    parameter int THR_HI     = 64,
    parameter int THR_LO     = 32,
    parameter int OCT_GROUP  = 16,
    parameter int RPT_PERIOD = 256,
    parameter int ERR_W      = $clog2(THR_HI + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              su_done,
    input  logic              su_bad,
    input  logic              su_abort,
    input  logic              oct_mode,
    input  logic              oct_tick,
    input  logic              thr_sel,
    input  logic              cnt_clr,
    input  logic              irq_mask,
    output logic              irq,
    output logic [UNIT_W-1:0] su_count,
    output logic [ERR_W-1:0]  err_count
);
    su_evt_t evt;
    logic    unit_evt;
    logic    wrap;
    logic    excess;

    // Any classified unit advances the unit counter
    always_comb unit_evt = evt.valid || evt.errd;

    su_evt_decode #(.OCT_GROUP(OCT_GROUP)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .su_done  (su_done),
        .su_bad   (su_bad),
        .su_abort (su_abort),
        .oct_mode (oct_mode),
        .oct_tick (oct_tick),
        .evt      (evt)
    );

    su_unit_ctr #(.UNIT_W(UNIT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .unit_evt (unit_evt),
        .count    (su_count),
        .wrap     (wrap)
    );

    su_err_bucket #(.THR_HI(THR_HI), .THR_LO(THR_LO), .ERR_W(ERR_W)) u_bkt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_clr   (cnt_clr),
        .thr_sel   (thr_sel),
        .evt       (evt),
        .wrap      (wrap),
        .err_count (err_count),
        .excess    (excess)
    );

    su_irq_gen #(.RPT_PERIOD(RPT_PERIOD)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_clr     (cnt_clr),
        .excess      (excess),
        .abort_cause (evt.abort_cause),
        .valid       (evt.valid),
        .irq_mask    (irq_mask),
        .irq         (irq)
    );

endmodule

// File: rtl/su_err_monitor_chk.sv
// su_err_monitor_chk: port-level properties of the error monitor, bound to the top.
module su_err_monitor_chk #(
    parameter int UNIT_W = 8,
    parameter int THR_HI = 64,
    parameter int THR_LO = 32,
    parameter int ERR_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              su_done,
    input logic              su_bad,
    input logic              su_abort,
    input logic              oct_mode,
    input logic              oct_tick,
    input logic              thr_sel,
    input logic              cnt_clr,
    input logic              irq_mask,
    input logic              irq,
    input logic [UNIT_W-1:0] su_count,
    input logic [ERR_W-1:0]  err_count
);
    logic [ERR_W-1:0] thr_cur;
    logic             err_in;

    // Current threshold and errored-unit strobe, seen from the ports
    always_comb begin
        thr_cur = thr_sel ? ERR_W'(THR_LO) : ERR_W'(THR_HI);
        err_in  = !cnt_clr && !oct_mode && su_done && (su_bad || su_abort);
    end

    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (su_count == '0) && (err_count == '0) && !irq);

    p_unit_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !su_done && !oct_mode) |=> $stable(su_count));

    p_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !oct_mode && !err_in) |=> (err_count <= $past(err_count)));

    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_in && (err_count >= thr_cur)) |=> (err_count == $past(thr_cur)));

    p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_count <= ERR_W'(THR_HI));

    p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |=> !irq);

    p_oct_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_mode && !oct_tick && !cnt_clr) |=> ($stable(su_count) && $stable(err_count)));

endmodule

bind su_err_monitor su_err_monitor_chk #(
    .UNIT_W (UNIT_W),
    .THR_HI (THR_HI),
    .THR_LO (THR_LO),
    .ERR_W  (ERR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .su_done   (su_done),
    .su_bad    (su_bad),
    .su_abort  (su_abort),
    .oct_mode  (oct_mode),
    .oct_tick  (oct_tick),
    .thr_sel   (thr_sel),
    .cnt_clr   (cnt_clr),
    .irq_mask  (irq_mask),
    .irq       (irq),
    .su_count  (su_count),
    .err_count (err_count)
);

// File: tb/su_err_monitor_tb_top.sv
// Bench: behavioural reference model compared with the design on every clock.
module su_err_monitor_tb_top;
    localparam int CLK_P = 10;
    localparam int RPT   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       su_done = 0, su_bad = 0, su_abort = 0;
    logic       oct_mode = 0, oct_tick = 0, thr_sel = 0, cnt_clr = 0, irq_mask = 0;
    logic       irq;
    logic [7:0] su_count;
    logic [6:0] err_count;

    int n_chk = 0, n_bad = 0, irq_seen = 0;
    // reference state
    int m_su = 0, m_err = 0, m_ph = 0, m_tmr = 0;
    bit m_sat = 0, m_rpt = 0, m_irq = 0;

    always #(CLK_P/2) clk = ~clk;

    su_err_monitor #(.RPT_PERIOD(RPT)) dut_i (
        .clk(clk), .rst_n(rst_n), .su_done(su_done), .su_bad(su_bad),
        .su_abort(su_abort), .oct_mode(oct_mode), .oct_tick(oct_tick),
        .thr_sel(thr_sel), .cnt_clr(cnt_clr), .irq_mask(irq_mask),
        .irq(irq), .su_count(su_count), .err_count(err_count)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit valid, errs, grp, cab, unit, wrap, exc, leak, fire;
        int thr;
        if (!rst_n || cnt_clr) begin
            m_su = 0; m_err = 0; m_ph = 0; m_tmr = 0;
            m_sat = 0; m_rpt = 0; m_irq = 0;
            return;
        end
        thr   = thr_sel ? 32 : 64;
        grp   = oct_mode && oct_tick && (m_ph == 15);
        valid = !oct_mode && su_done && !su_bad && !su_abort;
        errs  = (!oct_mode && su_done && (su_bad || su_abort)) || grp;
        cab   = (!oct_mode && su_done && su_abort) || grp;
        unit  = valid || errs;
        wrap  = unit && (m_su == 255);
        exc   = errs && (m_err >= thr);
        leak  = wrap && !m_sat && (m_err > 0);
        fire  = m_rpt && (m_tmr == RPT - 1) && !valid;
        m_irq = (exc || fire) && !irq_mask;
        m_tmr = (exc || fire || valid || !m_rpt) ? 0 : m_tmr + 1;
        if (exc && cab) m_rpt = 1; else if (valid) m_rpt = 0;
        if (exc) m_err = thr;
        else if (errs) m_err = m_err + 1 - int'(leak);
        else m_err = m_err - int'(leak);
        if (exc) m_sat = 1; else if (valid) m_sat = 0;
        if (!oct_mode) m_ph = 0; else if (oct_tick) m_ph = (m_ph + 1) % 16;
        if (unit) m_su = (m_su + 1) % 256;
    endtask

    // One clock: apply inputs, update model at the edge, compare after it
    task automatic cyc(input bit d, input bit b, input bit a, input bit t, input bit c);
        su_done = d; su_bad = b; su_abort = a; oct_tick = t; cnt_clr = c;
        @(posedge clk);
        model_step();
        #(CLK_P/4);
        chk(su_count == 8'(m_su), "R2 su_count", su_count, m_su);
        chk(err_count == 7'(m_err), "R3 err_count", err_count, m_err);
        chk(irq == m_irq, "R6 irq", irq, m_irq);
        if (irq) irq_seen++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    int base;

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0);
        chk(su_count == 0 && err_count == 0 && !irq, "R1 reset", su_count + err_count, 0);

        // R2, R3: mixed units with threshold 32
        thr_sel = 1;
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0);
        chk(su_count == 8, "R2 count units", su_count, 8);
        chk(err_count == 3, "R3 count errors", err_count, 3);

        // R5, R6: fill to 32, then excess on CRC-style errors
        for (int i = 0; i < 29; i++) cyc(1, 1, 0, 0, 0);
        chk(err_count == 32 && !irq, "R5 full no irq", err_count, 32);
        cyc(1, 1, 0, 0, 0);
        chk(irq == 1 && err_count == 32, "R6 excess pulse", irq, 1);
        cyc(0, 0, 0, 0, 0);
        chk(irq == 0, "R6 single cycle", irq, 0);
        base = irq_seen; idle(40);
        chk(irq_seen == base, "R8 no repeat for bad crc", irq_seen - base, 0);

        // R4: valid unit ends saturation, then a wrap leaks one
        cyc(1, 0, 0, 0, 0);
        while (su_count != 255) cyc(1, 0, 0, 0, 0);
        chk(err_count == 32, "R4 before wrap", err_count, 32);
        cyc(1, 0, 0, 0, 0);
        chk(su_count == 0 && err_count == 31, "R4 leak at wrap", err_count, 31);

        // R8: abort-caused excess repeats every RPT cycles
        cyc(1, 0, 1, 0, 0);
        cyc(1, 0, 1, 0, 0);
        chk(irq == 1, "R8 abort excess", irq, 1);
        base = irq_seen; idle(3 * RPT);
        chk(irq_seen - base == 3, "R8 repeats", irq_seen - base, 3);
        // R7: mask suppresses, nothing pending
        irq_mask = 1;
        base = irq_seen; idle(2 * RPT);
        chk(irq_seen == base, "R7 masked", irq_seen - base, 0);
        irq_mask = 0;
        cyc(0, 0, 0, 0, 0);
        chk(irq == 0, "R7 no pending", irq, 0);
        cyc(1, 0, 0, 0, 0);
        base = irq_seen; idle(3 * RPT);
        chk(irq_seen == base, "R8 valid stops repeat", irq_seen - base, 0);

        // R10, R1: clear beats a same-cycle errored unit
        cyc(1, 1, 0, 0, 1);
        chk(su_count == 0 && err_count == 0, "R10 clear priority", su_count + err_count, 0);

        // R9: octet mode
        oct_mode = 1;
        for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, 0);
        chk(su_count == 0 && err_count == 0, "R9 su_done ignored", su_count, 0);
        for (int i = 0; i < 32; i++) cyc(0, 0, 0, 1, 0);
        chk(su_count == 2 && err_count == 2, "R9 octet groups", err_count, 2);
        oct_mode = 0;

        // R5: threshold 64
        thr_sel = 0;
        for (int i = 0; i < 62; i++) cyc(1, 1, 0, 0, 0);
        chk(err_count == 64 && !irq, "R5 full at 64", err_count, 64);
        cyc(1, 1, 0, 0, 0);
        chk(irq == 1 && err_count == 64, "R5 excess at 64", irq, 1);

        // Mixed random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 199) == 0) thr_sel = ~thr_sel;
            if ($urandom_range(0, 99) == 0) irq_mask = ~irq_mask;
            if ($urandom_range(0, 299) == 0) oct_mode = ~oct_mode;
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
                $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 999) == 0);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule